// File: doc/BRIEF.md
# Clock-Synthesizer Reconfiguration Sequencer

This block runs a full reprogramming session on a clock synthesizer's dynamic reconfiguration port without software help. A single start pulse launches it. It asserts the synthesizer's reset and then writes eleven 16-bit setting words, taken from a parallel input bundle, to eleven fixed register addresses. It always writes them in the same order and waits for the port's ready reply after each write. When the last write has been acknowledged it releases reset, lets the synthesizer settle for a programmed number of clock cycles, and samples the lock input once. It then reports either success or a lock failure. If the ready reply does not arrive within a bounded number of cycles, the session ends with a timeout error.

The reconfiguration port uses a strobe and acknowledge handshake. The enable and write-enable pulse high for one cycle, with address and data valid in that same cycle. The port answers with a one-cycle ready pulse at some later cycle. Back-pressure is therefore the wait for ready: no new strobe is issued until it arrives. A ready pulse that comes while no access is outstanding is ignored. A separate software-controlled bit can hold the synthesizer in reset at any time, independent of the sequencer.

Top module: `clk_reconfig_seq`

## Requirements
- R1: After reset, busy, done, err_lock, err_timeout, drp_en, drp_we and synth_rst (with sw_rst low) are all low.
- R2: A session writes setting word k (bits [16k+15:16k] of cfg_words, k = 0..10) to the address at position k in the list 0x08, 0x09, 0x14, 0x15, 0x16, 0x18, 0x19, 0x1A, 0x28, 0x4E, 0x4F, with each address written once and in that order.
- R3: Each access drives drp_en and drp_we high for exactly one cycle, with drp_addr and drp_di valid in that cycle. The first strobe comes two cycles after the cycle in which start is sampled.
- R4: After a strobe, the next strobe is issued in the cycle after drp_rdy is seen high. drp_rdy is sampled only in the cycles after a strobe's own cycle and is ignored at all other times.
- R5: If drp_rdy stays low for TIMEOUT_CYCLES cycles after a strobe, the session ends with err_timeout high and synth_rst released. A ready that arrives in the TIMEOUT_CYCLES-th cycle is still accepted.
- R6: synth_rst is high from the cycle after start is accepted until the last write's ready is accepted. It is low in the cycle after that.
- R7: After release, lock is sampled in the SETTLE_CYCLES-th cycle. If lock is high, done is set; otherwise err_lock is set.
- R8: sw_rst high forces synth_rst high at once and has no effect on the sequencing.
- R9: busy is high from the cycle after an accepted start until the cycle after the session ends. A start pulse while busy is ignored.
- R10: done, err_lock and err_timeout are sticky until the next accepted start clears them, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the reconfiguration port |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| start | input | 1 | Pulse that starts a session when idle |
| cfg_words | input | 176 | Eleven packed setting words, word k in bits [16k+15:16k] |
| sw_rst | input | 1 | Software-controlled direct synthesizer reset |
| lock | input | 1 | Lock indication from the synthesizer |
| drp_rdy | input | 1 | Access-complete pulse from the port |
| drp_addr | output | 7 | Register address, valid with drp_en |
| drp_di | output | 16 | Write data, valid with drp_en |
| drp_en | output | 1 | One-cycle access strobe |
| drp_we | output | 1 | Write qualifier, high with drp_en |
| synth_rst | output | 1 | Synthesizer reset |
| busy | output | 1 | Session in progress |
| done | output | 1 | Sticky success flag |
| err_lock | output | 1 | Sticky lock-failure flag |
| err_timeout | output | 1 | Sticky ready-timeout flag |

## Verification
Two functions can fall in the same cycle: the ready reply and the expiry of the per-access timeout. The bench's port model is made to answer exactly TIMEOUT_CYCLES cycles after a strobe, and also one cycle later than that. The first case must finish with done and the second with err_timeout. A cycle-accurate reference model in the bench judges each cycle. A second overlap is a start pulse in the same cycle as the session's final step, or while busy. The model expects both to be ignored.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  localparam int NUM_REGS = 11;
  localparam int AW       = 7;
  localparam int DW       = 16;
  localparam int IW       = $clog2(NUM_REGS);

  typedef enum logic [2:0] {
    S_IDLE,
    S_PREP,
    S_ISSUE,
    S_WAIT,
    S_SETTLE
  } seq_state_t;

  function automatic logic [AW-1:0] reg_addr(input logic [IW-1:0] k);
    case (k)
      4'd0:    reg_addr = 7'h08;
      4'd1:    reg_addr = 7'h09;
      4'd2:    reg_addr = 7'h14;
      4'd3:    reg_addr = 7'h15;
      4'd4:    reg_addr = 7'h16;
      4'd5:    reg_addr = 7'h18;
      4'd6:    reg_addr = 7'h19;
      4'd7:    reg_addr = 7'h1A;
      4'd8:    reg_addr = 7'h28;
      4'd9:    reg_addr = 7'h4E;
      4'd10:   reg_addr = 7'h4F;
      default: reg_addr = 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/clkseq_tick.sv
module clkseq_tick #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  assign last = (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (clear)         cnt <= '0;
    else if (run && !last)  cnt <= cnt + 1'b1;
  end

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    last && run && !clear |=> last); // R7
endmodule

// File: rtl/clkseq_drp_drive.sv
module clkseq_drp_drive
  import clkseq_pkg::*;
(
  input  logic [NUM_REGS*DW-1:0] words,
  input  logic [IW-1:0]          idx,
  input  logic                   strobe,
  output logic [AW-1:0]          addr,
  output logic [DW-1:0]          di,
  output logic                   en,
  output logic                   we
);
  logic [DW-1:0] w_arr [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign w_arr[g] = words[g*DW +: DW];
  end

  logic [DW-1:0] sel_word;
  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IW'(i)) sel_word = w_arr[i];
  end

  assign en   = strobe;
  assign we   = strobe;
  assign addr = strobe ? reg_addr(idx) : '0;
  assign di   = strobe ? sel_word : '0;
endmodule

// File: rtl/clk_reconfig_seq.sv
module clk_reconfig_seq
  import clkseq_pkg::*;
#(
  parameter int SETTLE_CYCLES  = 10000,
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [NUM_REGS*DW-1:0] cfg_words,
  input  logic                   sw_rst,
  input  logic                   lock,
  input  logic                   drp_rdy,
  output logic [AW-1:0]          drp_addr,
  output logic [DW-1:0]          drp_di,
  output logic                   drp_en,
  output logic                   drp_we,
  output logic                   synth_rst,
  output logic                   busy,
  output logic                   done,
  output logic                   err_lock,
  output logic                   err_timeout
);
  seq_state_t    state;
  logic [IW-1:0] idx;
  logic          to_last, settle_last;

  clkseq_tick #(.LIMIT(TIMEOUT_CYCLES)) u_timeout (
    .clk(clk), .rst_n(rst_n),
    .clear(state != S_WAIT), .run(state == S_WAIT), .last(to_last)
  );

  clkseq_tick #(.LIMIT(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n),
    .clear(state != S_SETTLE), .run(state == S_SETTLE), .last(settle_last)
  );

  clkseq_drp_drive u_drive (
    .words(cfg_words), .idx(idx), .strobe(state == S_ISSUE),
    .addr(drp_addr), .di(drp_di), .en(drp_en), .we(drp_we)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      idx         <= '0;
      done        <= 1'b0;
      err_lock    <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state       <= S_PREP;
          idx         <= '0;
          done        <= 1'b0;
          err_lock    <= 1'b0;
          err_timeout <= 1'b0;
        end
        S_PREP:  state <= S_ISSUE;
        S_ISSUE: state <= S_WAIT;
        S_WAIT: begin
          if (drp_rdy) begin
            if (idx == IW'(NUM_REGS - 1)) state <= S_SETTLE;
            else begin
              idx   <= idx + 1'b1;
              state <= S_ISSUE;
            end
          end else if (to_last) begin
            state       <= S_IDLE;
            err_timeout <= 1'b1;
          end
        end
        S_SETTLE: if (settle_last) begin
          state <= S_IDLE;
          if (lock) done     <= 1'b1;
          else      err_lock <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state != S_IDLE);
  assign synth_rst = sw_rst || (state == S_PREP) || (state == S_ISSUE) || (state == S_WAIT);

  AST_EN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |=> !drp_en); // R3
  AST_RST_COVERS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    drp_en |-> synth_rst); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_lock, err_timeout})); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !drp_en); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R10
  AST_BUSY_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done && !err_lock && !err_timeout); // R9
endmodule

// File: tb/tb_clk_reconfig_seq.sv
module tb_clk_reconfig_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SET = 20;
  localparam int TO  = 8;

  logic clk = 0, rst_n = 0, start = 0, sw_rst = 0, lock = 0, stray = 0;
  logic [175:0] cfg_words = '0;
  logic [6:0] drp_addr;
  logic [15:0] drp_di;
  logic drp_en, drp_we, synth_rst, busy, done, err_lock, err_timeout, drp_rdy;

  int checks = 0, fails = 0, cycles = 0;
  int lat = 1, rcnt = 0;
  int log_a[$];
  int log_d[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_reconfig_seq #(.SETTLE_CYCLES(SET), .TIMEOUT_CYCLES(TO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_words(cfg_words),
    .sw_rst(sw_rst), .lock(lock), .drp_rdy(drp_rdy), .drp_addr(drp_addr),
    .drp_di(drp_di), .drp_en(drp_en), .drp_we(drp_we), .synth_rst(synth_rst),
    .busy(busy), .done(done), .err_lock(err_lock), .err_timeout(err_timeout));

  assign drp_rdy = (rcnt == 1) || stray;

  // port model: records writes, answers ready 'lat' cycles later (0 = never)
  always @(posedge clk) begin
    if (drp_en && drp_we) begin
      log_a.push_back(int'(drp_addr));
      log_d.push_back(int'(drp_di));
      rcnt <= lat;
    end else if (rcnt > 0) rcnt <= rcnt - 1;
  end

  function automatic int exp_addr(int k);
    int tbl[11] = '{8, 9, 20, 21, 22, 24, 25, 26, 40, 78, 79};
    return tbl[k];
  endfunction

  // behavioural reference: 0 idle, 1 prep, 2 strobe, 3 wait ready, 4 settle
  int m_st = 0, m_idx = 0, m_w = 0, m_s = 0;
  bit m_d = 0, m_el = 0, m_et = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 0; m_d = 0; m_el = 0; m_et = 0;
    end else begin
      case (m_st)
        0: if (start) begin m_st = 1; m_idx = 0; m_d = 0; m_el = 0; m_et = 0; end
        1: m_st = 2;
        2: begin m_st = 3; m_w = 0; end
        3: if (drp_rdy) begin
             if (m_idx == 10) begin m_st = 4; m_s = 0; end
             else begin m_idx++; m_st = 2; end
           end else if (m_w == TO - 1) begin m_st = 0; m_et = 1; end
           else m_w++;
        4: if (m_s == SET - 1) begin
             m_st = 0;
             if (lock) m_d = 1; else m_el = 1;
           end else m_s++;
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9", "busy", int'(busy), int'(m_st != 0));
      chk("R3", "drp_en", int'(drp_en), int'(m_st == 2));
      chk("R3", "drp_we", int'(drp_we), int'(m_st == 2));
      chk("R6", "synth_rst", int'(synth_rst), int'(sw_rst || (m_st >= 1 && m_st <= 3)));
      chk("R7", "done", int'(done), int'(m_d));
      chk("R7", "err_lock", int'(err_lock), int'(m_el));
      chk("R5", "err_timeout", int'(err_timeout), int'(m_et));
      if (m_st == 2) begin
        chk("R2", "drp_addr", int'(drp_addr), exp_addr(m_idx));
        chk("R2", "drp_di", int'(drp_di), int'(cfg_words[16*m_idx +: 16]));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic load(int seed);
    for (int k = 0; k < 11; k++)
      cfg_words[16*k +: 16] = 16'(16'hA000 + seed * 16'h0101 + k);
  endtask

  task automatic run(int seed, int l, bit lk, bit poke);
    load(seed); lat = l; lock = lk;
    log_a.delete(); log_d.delete();
    start = 1; tick(); start = 0;
    if (poke) begin tick(); tick(); start = 1; tick(); start = 0; end // R9 start while busy
    for (int i = 0; i < 2000 && busy; i++) tick();
    tick();
  endtask

  task automatic check_log(string tag);
    chk("R2", {tag, " write count"}, log_a.size(), 11);
    for (int k = 0; k < 11 && k < log_a.size(); k++) begin
      chk("R2", {tag, " addr order"}, log_a[k], exp_addr(k));
      chk("R2", {tag, " data"}, log_d[k], int'(cfg_words[16*k +: 16]));
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 reset state
    chk("R1", "reset busy", int'(busy), 0);
    chk("R1", "reset flags", int'(done | err_lock | err_timeout), 0);
    chk("R1", "reset synth_rst", int'(synth_rst), 0);
    chk("R1", "reset drp_en", int'(drp_en), 0);
    // R4 stray ready in idle is ignored
    stray = 1; tick(); stray = 0; tick();
    chk("R4", "stray ready busy", int'(busy), 0);
    chk("R4", "stray ready no write", log_a.size(), 0);
    // R8 software reset
    sw_rst = 1; tick();
    chk("R8", "sw_rst forces synth_rst", int'(synth_rst), 1);
    sw_rst = 0; tick();
    chk("R8", "sw_rst release", int'(synth_rst), 0);
    // R2 R7 nominal session
    run(1, 1, 1, 0);
    check_log("lat1");
    chk("R7", "done after lock", int'(done), 1);
    repeat (5) tick();
    chk("R10", "done sticky", int'(done), 1);
    // R4 slower ready, start while busy ignored (R9), sw_rst during run (R8)
    sw_rst = 1;
    run(2, 3, 1, 1);
    sw_rst = 0;
    check_log("lat3");
    chk("R9", "poked run done", int'(done), 1);
    // R7 lock failure
    run(3, 2, 0, 0);
    check_log("nolock");
    chk("R7", "err_lock", int'(err_lock), 1);
    chk("R10", "done cleared", int'(done), 0);
    // R5 ready on the final allowed cycle is accepted
    run(4, TO, 1, 0);
    check_log("edge");
    chk("R5", "edge ready accepted", int'(done), 1);
    // R5 ready one cycle too late times out
    run(5, TO + 1, 1, 0);
    chk("R5", "late ready times out", int'(err_timeout), 1);
    chk("R5", "timeout single write", log_a.size(), 1);
    chk("R5", "timeout releases reset", int'(synth_rst), 0);
    // R5 no ready at all
    run(6, 0, 1, 0);
    chk("R5", "no ready timeout", int'(err_timeout), 1);
    chk("R10", "one flag only", int'(done) + int'(err_lock) + int'(err_timeout), 1);
    // R10 next start clears flag
    run(7, 1, 1, 0);
    chk("R10", "timeout cleared", int'(err_timeout), 0);
    chk("R7", "recovered done", int'(done), 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule